// File: doc/BRIEF.md
# Dual-Fetch FIR Multiply-Accumulate Engine

This block produces one output of an N-tap finite impulse response filter each time it is asked. It keeps the filter weights in one small bank and the recent input history in a second, independent bank. Each cycle of a computation it reads one weight and one sample together, one from each bank, through two ring pointers. It pushes the pair through a registered multiplier into a saturating accumulator, so it retires one tap per clock.

A one-cycle `start` pulse begins a computation. The weight pointer starts at tap 0 and moves upward. The sample pointer starts at the most recently written sample and moves toward older ones. When the last product has been added, the accumulator is scaled down by a fixed shift (Q15 by default), clamped to the output width and presented on `result`, together with a one-cycle `done` pulse.

New input samples arrive on a separate write port. Each one replaces the oldest entry in the history ring. Weights are loaded by address through their own write port.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset `done` is low, `result` is 0, and every stored weight and sample is 0, so a computation started right after reset yields 0.
- R2: With weight k written at `coef_addr` = k, `result` equals clamp((sum over k of weight[k] × x[k]) >>> SHIFT), where x[0] is the newest sample, x[1] the one before it, and so on. All values are signed two's complement, and the shift is arithmetic.
- R3: Taps are processed one per clock. `done` rises NTAPS+2 clock edges after the edge that samples `start`, and it is high for exactly one cycle.
- R4: `result` changes only on the cycle `done` is high, and it holds its value until the next `done`.
- R5: A scaled sum above 32767 gives `result` = 32767, and one below -32768 gives -32768. The accumulator saturates instead of wrapping.
- R6: Each `smp_we` stores `smp_data` over the oldest stored sample. After more than NTAPS writes, only the latest NTAPS samples take part.
- R7: A `start` pulse that arrives while a computation is running is ignored. It neither restarts nor extends the running computation, and it does not cause a second `done`.
- R8: A sample written while a computation is running does not change that computation's result. It is stored when `done` is raised and is used by the next computation.
- R9: `coef_we` writes `coef_data` into weight slot `coef_addr`, and the new weight takes effect in the next computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Weight write strobe |
| coef_addr | input | $clog2(NTAPS) | Weight slot (tap index) to write |
| coef_data | input | DW | Signed weight value |
| smp_we | input | 1 | Sample write strobe |
| smp_data | input | DW | Signed new input sample |
| start | input | 1 | One-cycle request to compute one output |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | OW | Saturated, scaled filter output |

## Verification
The bench uses an asymmetric weight set and ramp samples. A design that walked the history in the wrong direction, or paired the wrong weight with a sample, would produce a visibly wrong sum. The bench drives full-scale positive and full-scale negative inputs. A design lacking output clamping would show a wrapped value, often with the wrong sign. The bench writes more samples than the ring holds, so a pointer that fails to wrap corrupts the result. It also injects a `start` and a sample write in the middle of a computation: a design that restarted would report a late or doubled `done`, and one that wrote the sample at once would fold the new sample into the running result.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } fir_state_e;

endpackage

// File: rtl/fir_ring_ptr.sv
// Ring pointer with post-step and wrap; DOWN selects the step direction.
module fir_ring_ptr #(
    parameter int DEPTH = 8,
    parameter bit DOWN  = 1'b0,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] load_val,
    input  logic          step,
    output logic [IW-1:0] ptr
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [IW-1:0] ptr_d, ptr_q, stepped;

    generate
        if (DOWN) begin : g_down
            always_comb stepped = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
        end else begin : g_up
            always_comb stepped = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    endgenerate

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = load_val;
        end else if (step) begin
            ptr_d = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/fir_dual_bank.sv
// Weight bank and sample history ring, read in parallel; sample writes
// may be parked in a one-entry hold slot while a computation runs.
module fir_dual_bank #(
    parameter int N  = 8,
    parameter int DW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_we,
    input  logic [IW-1:0] coef_addr,
    input  logic [DW-1:0] coef_data,
    input  logic          smp_we,
    input  logic [DW-1:0] smp_data,
    input  logic          hold_wr,
    input  logic          commit,
    input  logic [IW-1:0] rd_caddr,
    input  logic [IW-1:0] rd_saddr,
    output logic [DW-1:0] rd_coef,
    output logic [DW-1:0] rd_smp,
    output logic [IW-1:0] newest,
    output logic          pend_vld
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    typedef struct packed {
        logic [N-1:0][DW-1:0] cmem;
        logic [N-1:0][DW-1:0] smem;
        logic [IW-1:0]        wr;
        logic                 pend;
        logic [DW-1:0]        pend_data;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic [IW-1:0] ring_inc(input logic [IW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        logic [IW-1:0] base;
        bank_d = bank_q;
        base   = bank_q.wr;

        if (coef_we && (int'(coef_addr) < N)) begin
            bank_d.cmem[coef_addr] = coef_data;
        end

        if (commit && bank_q.pend) begin
            bank_d.smem[bank_q.wr] = bank_q.pend_data;
            base                   = ring_inc(bank_q.wr);
            bank_d.wr              = base;
            bank_d.pend            = 1'b0;
        end

        if (smp_we) begin
            if (hold_wr) begin
                bank_d.pend      = 1'b1;
                bank_d.pend_data = smp_data;
            end else begin
                bank_d.smem[base] = smp_data;
                bank_d.wr         = ring_inc(base);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_coef  = bank_q.cmem[rd_caddr];
    assign rd_smp   = bank_q.smem[rd_saddr];
    assign newest   = (bank_q.wr == '0) ? LAST : bank_q.wr - 1'b1;
    assign pend_vld = bank_q.pend;

endmodule

// File: rtl/fir_mac_pipe.sv
// Registered multiplier followed by a saturating accumulator.
module fir_mac_pipe #(
    parameter int DW = 16,
    parameter int AW = 40,
    localparam int PW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          issue,
    input  logic [DW-1:0] coef,
    input  logic [DW-1:0] smp,
    output logic [PW-1:0] prod,
    output logic          prod_vld,
    output logic [AW-1:0] acc
);

    localparam logic [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

    typedef struct packed {
        logic [PW-1:0] prod;
        logic          vld;
        logic [AW-1:0] acc;
    } mac_t;

    mac_t mac_d, mac_q;

    always_comb begin
        logic signed [AW:0] sum;
        mac_d     = mac_q;
        mac_d.vld = issue;
        if (issue) begin
            mac_d.prod = PW'($signed(coef) * $signed(smp));
        end

        sum = $signed({mac_q.acc[AW-1], mac_q.acc})
            + $signed({{(AW+1-PW){mac_q.prod[PW-1]}}, mac_q.prod});

        if (clr) begin
            mac_d.acc = '0;
        end else if (mac_q.vld) begin
            if (sum[AW] != sum[AW-1]) begin
                mac_d.acc = sum[AW] ? ACC_MIN : ACC_MAX;
            end else begin
                mac_d.acc = sum[AW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mac_q <= '0;
        end else begin
            mac_q <= mac_d;
        end
    end

    assign prod     = mac_q.prod;
    assign prod_vld = mac_q.vld;
    assign acc      = mac_q.acc;

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
    import fir_mac_pkg::*;
#(
    parameter int NTAPS = 8,
    parameter int DW    = 16,
    parameter int AW    = 40,
    parameter int OW    = 16,
    parameter int SHIFT = 15,
    localparam int IW   = (NTAPS > 1) ? $clog2(NTAPS) : 1,
    localparam int CW   = $clog2(NTAPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_we,
    input  logic [IW-1:0] coef_addr,
    input  logic [DW-1:0] coef_data,
    input  logic          smp_we,
    input  logic [DW-1:0] smp_data,
    input  logic          start,
    output logic          done,
    output logic [OW-1:0] result
);

    localparam logic [CW-1:0]        LAST_TAP = CW'(NTAPS - 1);
    localparam logic signed [AW-1:0] OUT_MAX  = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW-1:0] OUT_MIN  = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    typedef struct packed {
        fir_state_e    state;
        logic [CW-1:0] tap;
        logic          done;
        logic [OW-1:0] result;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          start_acc, run_busy, hold_wr, commit, issue;
    logic [IW-1:0] cptr, sptr, newest;
    logic [DW-1:0] rd_coef, rd_smp;
    logic [2*DW-1:0] prod;
    logic          prod_vld, pend_vld;
    logic [AW-1:0] acc;
    logic signed [AW-1:0] scaled;

    assign start_acc = start && (ctl_q.state == ST_IDLE);
    assign run_busy  = (ctl_q.state == ST_RUN) || (ctl_q.state == ST_DRAIN);
    assign hold_wr   = run_busy || start_acc;
    assign commit    = (ctl_q.state == ST_FINISH);
    assign issue     = (ctl_q.state == ST_RUN);

    fir_dual_bank #(.N(NTAPS), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .coef_we  (coef_we),
        .coef_addr(coef_addr),
        .coef_data(coef_data),
        .smp_we   (smp_we),
        .smp_data (smp_data),
        .hold_wr  (hold_wr),
        .commit   (commit),
        .rd_caddr (cptr),
        .rd_saddr (sptr),
        .rd_coef  (rd_coef),
        .rd_smp   (rd_smp),
        .newest   (newest),
        .pend_vld (pend_vld)
    );

    fir_ring_ptr #(.DEPTH(NTAPS), .DOWN(1'b0)) u_cptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_acc),
        .load_val('0),
        .step    (issue),
        .ptr     (cptr)
    );

    fir_ring_ptr #(.DEPTH(NTAPS), .DOWN(1'b1)) u_sptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_acc),
        .load_val(newest),
        .step    (issue),
        .ptr     (sptr)
    );

    fir_mac_pipe #(.DW(DW), .AW(AW)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_acc),
        .issue   (issue),
        .coef    (rd_coef),
        .smp     (rd_smp),
        .prod    (prod),
        .prod_vld(prod_vld),
        .acc     (acc)
    );

    assign scaled = $signed(acc) >>> SHIFT;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_acc) begin
                    ctl_d.state = ST_RUN;
                    ctl_d.tap   = '0;
                end
            end
            ST_RUN: begin
                ctl_d.tap = ctl_q.tap + 1'b1;
                if (ctl_q.tap == LAST_TAP) begin
                    ctl_d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                ctl_d.state = ST_FINISH;
            end
            ST_FINISH: begin
                ctl_d.state = ST_IDLE;
                ctl_d.done  = 1'b1;
                if (scaled > OUT_MAX) begin
                    ctl_d.result = OUT_MAX[OW-1:0];
                end else if (scaled < OUT_MIN) begin
                    ctl_d.result = OUT_MIN[OW-1:0];
                end else begin
                    ctl_d.result = scaled[OW-1:0];
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, tap: '0, done: 1'b0, result: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done   = ctl_q.done;
    assign result = ctl_q.result;

endmodule

// File: rtl/fir_mac_chk.sv
module fir_mac_chk #(
    parameter int NTAPS = 8,
    parameter int DW    = 16,
    parameter int AW    = 40,
    parameter int OW    = 16,
    localparam int IW   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [OW-1:0] result,
    input logic          smp_we,
    input logic          hold_wr,
    input logic          pend_vld,
    input logic [IW-1:0] cptr,
    input logic [IW-1:0] sptr,
    input logic          prod_vld,
    input logic [2*DW-1:0] prod,
    input logic [AW-1:0] acc
);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cptr) < NTAPS) && (int'(sptr) < NTAPS));

    p_hold_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_wr && smp_we) |=> pend_vld);

    p_no_wrap_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_vld && !acc[AW-1] && !prod[2*DW-1]) |=> !acc[AW-1]);

    p_no_wrap_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_vld && acc[AW-1] && prod[2*DW-1]) |=> acc[AW-1]);

endmodule

bind fir_mac_engine fir_mac_chk #(
    .NTAPS(NTAPS), .DW(DW), .AW(AW), .OW(OW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .result  (result),
    .smp_we  (smp_we),
    .hold_wr (hold_wr),
    .pend_vld(pend_vld),
    .cptr    (cptr),
    .sptr    (sptr),
    .prod_vld(prod_vld),
    .prod    (prod),
    .acc     (acc)
);

// File: tb/fir_mac_engine_tb.sv
`timescale 1ns/1ps
module fir_mac_engine_tb;

    localparam int NTAPS = 8;
    localparam int DW    = 16;
    localparam int OW    = 16;
    localparam int IW    = $clog2(NTAPS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coef_we = 1'b0;
    logic [IW-1:0] coef_addr = '0;
    logic [DW-1:0] coef_data = '0;
    logic          smp_we = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          start = 1'b0;
    logic          done;
    logic [OW-1:0] result;

    int checks = 0;
    int errors = 0;

    int m_coef [NTAPS];
    int m_smp  [NTAPS];
    int m_wr = 0;

    always #10 clk = ~clk;

    fir_mac_engine #(.NTAPS(NTAPS), .DW(DW), .OW(OW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .smp_we(smp_we), .smp_data(smp_data),
        .start(start), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int expected_out();
        longint sum = 0;
        longint sh;
        for (int k = 0; k < NTAPS; k++) begin
            sum += longint'(m_coef[k]) * longint'(m_smp[(m_wr - 1 - k + 2*NTAPS) % NTAPS]);
        end
        sh = sum >>> 15;
        if (sh > 32767) sh = 32767;
        if (sh < -32768) sh = -32768;
        return int'(sh);
    endfunction

    task automatic put_coef(input int k, input int v);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = IW'(k); coef_data = DW'(v);
        @(negedge clk);
        coef_we = 1'b0;
        m_coef[k] = v;
    endtask

    task automatic put_smp(input int v);
        @(negedge clk);
        smp_we = 1'b1; smp_data = DW'(v);
        @(negedge clk);
        smp_we = 1'b0;
        m_smp[m_wr] = v;
        m_wr = (m_wr + 1) % NTAPS;
    endtask

    // Runs one computation; optional mid-run start pulse and sample write.
    task automatic run_one(input string req, input int exp,
                           input bit extra_start, input bit mid_write, input int wval);
        int cyc = 0;
        int res;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (cyc == 3) begin
                start = extra_start;
                smp_we = mid_write;
                smp_data = DW'(wval);
            end else begin
                start = 1'b0;
                smp_we = 1'b0;
            end
        end
        res = int'($signed(result));
        check(cyc == NTAPS + 2, "R3", "done latency", cyc, NTAPS + 2);
        check(res == exp, req, "result", res, exp);
        @(negedge clk);
        check(done == 1'b0, "R3", "done width", done, 0);
        repeat (NTAPS + 4) begin
            @(negedge clk);
            if (done || int'($signed(result)) != res) begin
                check(1'b0, (extra_start ? "R7" : "R4"), "unexpected update", int'($signed(result)), res);
                break;
            end
        end
        if (mid_write) begin
            m_smp[m_wr] = wval;
            m_wr = (m_wr + 1) % NTAPS;
        end
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(result == '0, "R1", "result after reset", result, 0);
        run_one("R1", 0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_order();
        int w[NTAPS] = '{16384, 8192, -4096, 2048, 1000, -1000, 300, 7};
        for (int k = 0; k < NTAPS; k++) put_coef(k, w[k]);
        for (int i = 1; i <= NTAPS; i++) put_smp(i * 1000);
        run_one("R2", expected_out(), 1'b0, 1'b0, 0);
        put_coef(2, 20000);
        run_one("R9", expected_out(), 1'b0, 1'b0, 0);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < NTAPS; k++) put_coef(k, 32767);
        for (int i = 0; i < NTAPS; i++) put_smp(32767);
        check(expected_out() == 32767, "R5", "model positive clamp", expected_out(), 32767);
        run_one("R5", 32767, 1'b0, 1'b0, 0);
        for (int i = 0; i < NTAPS; i++) put_smp(-32768);
        run_one("R5", -32768, 1'b0, 1'b0, 0);
    endtask

    task automatic t_wrap();
        int w[NTAPS] = '{3000, -2000, 1500, 900, -700, 500, 250, -100};
        for (int k = 0; k < NTAPS; k++) put_coef(k, w[k]);
        for (int i = 0; i < NTAPS + 3; i++) put_smp((i * 3217) % 20000 - 9000);
        run_one("R6", expected_out(), 1'b0, 1'b0, 0);
    endtask

    task automatic t_busy_start();
        put_smp(12345);
        run_one("R7", expected_out(), 1'b1, 1'b0, 0);
    endtask

    task automatic t_busy_write();
        run_one("R8", expected_out(), 1'b0, 1'b1, -31000);
        run_one("R8", expected_out(), 1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_saturate();
        t_wrap();
        t_busy_start();
        t_busy_write();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        check(1'b0, "R3", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule